// File: doc/BRIEF.md
# Speculative Load Fault Screener

This block screens a speculative load before memory is touched. In one request cycle it takes the base register value, an optional displacement register value or a signed immediate, the destination register index, the access size and an integer/float selector. It forms the effective address and checks whether the address and the destination register are aligned for the access size. Instead of trapping, it defers any fault by setting a per-register deferred-fault flag. It keeps two 64-entry flag vectors, one for integer registers and one for float registers. A fault flag already set on a source register is carried to the destination, and that load is suppressed.

An optional fault log can be switched on through control inputs. When it is on, each screened load claims the lowest free status slot among the first `log_nen` slots. The slot records the load's details, and a paired register holds its effective address. If no slot is free, an error pulse is raised. The result of a request appears one clock after the request: the load decision, the updated flags and the slot contents.

Top module: `nel_screen`

## Requirements
- R1: The effective address is `base_val + disp_val` when `disp_use` is 1, and otherwise `base_val` plus `imm` sign-extended from IMM_W bits. It is observable in the address register of a logged slot.
- R2: Size codes are 0 byte, 1 halfword, 2 word, 3 doubleword and 4 quadword. A byte never faults on alignment. A halfword faults when address bit 0 is 1, and a word faults when address bits 1:0 are nonzero.
- R3: A doubleword address-faults when address bits 2:0 are nonzero and register-faults when `dst_idx` is odd. A quadword address-faults when address bits 3:0 are nonzero and register-faults when `dst_idx` bits 1:0 are nonzero.
- R4: When either fault is detected, the destination flag is set and `do_load` is 1.
- R5: Without a fault, if the flag of `base_idx` is set, or the flag of `disp_idx` is set while `disp_use` is 1, the destination flag is set and `do_load` is 0. Otherwise the destination flag is cleared and `do_load` is 1. `disp_idx` has no effect when `disp_use` is 0.
- R6: Flags are read and written in the float vector `fne` when `is_fp` is 1, and in the integer vector `gne` otherwise. The other vector is unchanged.
- R7: Logging is active only when both `log_valid` and `log_en` are 1. Otherwise no slot changes.
- R8: An active log writes the lowest-numbered slot whose valid bit is 0 among slots below `log_nen`. When no such slot exists, `alloc_err` pulses and no slot changes.
- R9: Slot status layout, LSB first: valid (bit 0), address-valid (bit 1), float flag (bit 2), destination index (6 bits from bit 3), size code (3 bits from bit 9), slot index (SIW bits from bit 12), address-misaligned code (bit 12+SIW), register-misaligned code (bit 13+SIW). The two code bits are 1 when that fault was found.
- R10: `done`, `do_load` and `alloc_err` and all state updates take effect at the clock edge that samples `req`. Flags and slots do not change while `req` is 0.
- R11: After reset both flag vectors, all slots, `done`, `do_load` and `alloc_err` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Screen one load this cycle |
| base_idx | input | 6 | Base register index |
| base_val | input | AW | Base register value |
| disp_use | input | 1 | Use displacement register instead of immediate |
| disp_idx | input | 6 | Displacement register index |
| disp_val | input | AW | Displacement register value |
| imm | input | IMM_W | Signed immediate displacement |
| dst_idx | input | 6 | Destination register index |
| size | input | 3 | Access size code |
| is_fp | input | 1 | Float destination/vector select |
| log_valid | input | 1 | Log control valid |
| log_en | input | 1 | Log enable |
| log_nen | input | NW | Number of usable slots |
| done | output | 1 | Result valid pulse |
| do_load | output | 1 | Perform the load |
| alloc_err | output | 1 | No free slot while logging |
| gne | output | NREG | Integer deferred-fault flags |
| fne | output | NREG | Float deferred-fault flags |
| slot_stat | output | NSLOT*STW | Slot status words, slot 0 lowest |
| slot_addr | output | NSLOT*AW | Slot address registers, slot 0 lowest |

## Verification
Every result of a request is registered once. `done`, `do_load`, `alloc_err`, the flag bits and the slot words are therefore all due on the first rising edge after the cycle in which `req` is high. The bench drives each request on a falling edge and removes it on the next falling edge. It reads every output at that second falling edge, half a period after the updating edge. One more idle falling edge is then sampled to confirm that `done` has dropped and that the state is held.

// File: rtl/nel_screen.sv
module nel_screen #(
  parameter int NSLOT = 8,
  parameter int AW    = 32,
  parameter int IMM_W = 12,
  parameter int NREG  = 64,
  localparam int RIW  = $clog2(NREG),
  localparam int SIW  = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int NW   = $clog2(NSLOT + 1),
  localparam int STW  = 8 + RIW + SIW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req,
  input  logic [RIW-1:0]       base_idx,
  input  logic [AW-1:0]        base_val,
  input  logic                 disp_use,
  input  logic [RIW-1:0]       disp_idx,
  input  logic [AW-1:0]        disp_val,
  input  logic [IMM_W-1:0]     imm,
  input  logic [RIW-1:0]       dst_idx,
  input  logic [2:0]           size,
  input  logic                 is_fp,
  input  logic                 log_valid,
  input  logic                 log_en,
  input  logic [NW-1:0]        log_nen,
  output logic                 done,
  output logic                 do_load,
  output logic                 alloc_err,
  output logic [NREG-1:0]      gne,
  output logic [NREG-1:0]      fne,
  output logic [NSLOT*STW-1:0] slot_stat,
  output logic [NSLOT*AW-1:0]  slot_addr
);
  localparam int P_DST = 3;
  localparam int P_SZ  = 3 + RIW;
  localparam int P_IDX = 6 + RIW;
  localparam int P_EC  = 6 + RIW + SIW;
  localparam int P_REC = 7 + RIW + SIW;

  logic [STW-1:0] stat_q [NSLOT];
  logic [AW-1:0]  addr_q [NSLOT];
  logic [AW-1:0]  ea;
  logic           ec, rec, src_ne, fault, logging, hit;
  logic [NREG-1:0] cur;
  logic [SIW-1:0] sel;
  logic [STW-1:0] new_stat;

  assign ea = base_val + (disp_use ? disp_val : {{(AW-IMM_W){imm[IMM_W-1]}}, imm});

  always_comb begin
    ec = 1'b0;
    rec = 1'b0;
    case (size)
      3'd1: ec = ea[0];
      3'd2: ec = |ea[1:0];
      3'd3: begin ec = |ea[2:0]; rec = dst_idx[0]; end
      3'd4: begin ec = |ea[3:0]; rec = |dst_idx[1:0]; end
      default: ;
    endcase
  end

  assign cur     = is_fp ? fne : gne;
  assign src_ne  = cur[base_idx] | (disp_use & cur[disp_idx]);
  assign fault   = ec | rec;
  assign logging = log_valid & log_en;

  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (i < int'(log_nen) && !stat_q[i][0]) begin
        hit = 1'b1;
        sel = SIW'(i);
      end
    end
  end

  always_comb begin
    new_stat = '0;
    new_stat[0] = 1'b1;
    new_stat[1] = 1'b1;
    new_stat[2] = is_fp;
    new_stat[P_DST +: RIW] = dst_idx;
    new_stat[P_SZ +: 3] = size;
    new_stat[P_IDX +: SIW] = sel;
    new_stat[P_EC] = ec;
    new_stat[P_REC] = rec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
      do_load <= 1'b0;
      alloc_err <= 1'b0;
      gne <= '0;
      fne <= '0;
      for (int i = 0; i < NSLOT; i++) begin
        stat_q[i] <= '0;
        addr_q[i] <= '0;
      end
    end else begin
      done <= req;
      alloc_err <= 1'b0;
      if (req) begin
        do_load <= fault | ~src_ne;
        alloc_err <= logging & ~hit;
        if (is_fp) fne[dst_idx] <= fault | src_ne;
        else       gne[dst_idx] <= fault | src_ne;
        if (logging && hit) begin
          stat_q[sel] <= new_stat;
          addr_q[sel] <= ea;
        end
      end
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_flat
    assign slot_stat[g*STW +: STW] = stat_q[g];
    assign slot_addr[g*AW +: AW]   = addr_q[g];
  end
endmodule

module nel_screen_chk #(
  parameter int NSLOT = 8,
  parameter int AW    = 32,
  parameter int NREG  = 64,
  parameter int RIW   = 6,
  parameter int STW   = 17
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req,
  input logic                 is_fp,
  input logic                 log_valid,
  input logic                 log_en,
  input logic [RIW-1:0]       dst_idx,
  input logic                 done,
  input logic                 do_load,
  input logic                 alloc_err,
  input logic [NREG-1:0]      gne,
  input logic [NREG-1:0]      fne,
  input logic [NSLOT*STW-1:0] slot_stat
);
  // R10
  done_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> done);
  // R10
  idle_holds_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> ($stable(gne) && $stable(fne) && $stable(slot_stat)));
  // R5
  suppress_marks_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !is_fp) ##1 (done && !do_load) |-> gne[$past(dst_idx)]);
  // R6
  int_keeps_fp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !is_fp) |=> $stable(fne));
  // R7
  nolog_keeps_slots_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !(log_valid && log_en)) |=> ($stable(slot_stat) && !alloc_err));
  // R8
  err_only_on_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_err |-> done);
endmodule

bind nel_screen nel_screen_chk #(.NSLOT(NSLOT), .AW(AW), .NREG(NREG), .RIW(RIW), .STW(STW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .is_fp(is_fp), .log_valid(log_valid),
  .log_en(log_en), .dst_idx(dst_idx), .done(done), .do_load(do_load),
  .alloc_err(alloc_err), .gne(gne), .fne(fne), .slot_stat(slot_stat));

// File: tb/test_nel_screen.sv
module test_nel_screen;
  localparam int CLK_P = 10;
  localparam int NSLOT = 8, AW = 32, IMM_W = 12, NREG = 64;
  localparam int SIW = 3, NW = 4, STW = 17;

  logic clk = 0, rst_n = 0, req = 0;
  logic [5:0] base_idx = 0, disp_idx = 0, dst_idx = 0;
  logic [AW-1:0] base_val = 0, disp_val = 0;
  logic disp_use = 0, is_fp = 0, log_valid = 0, log_en = 0;
  logic [IMM_W-1:0] imm = 0;
  logic [2:0] size = 0;
  logic [NW-1:0] log_nen = 0;
  logic done, do_load, alloc_err;
  logic [NREG-1:0] gne, fne;
  logic [NSLOT*STW-1:0] slot_stat;
  logic [NSLOT*AW-1:0] slot_addr;
  int nchk = 0, nerr = 0;
  bit ended = 0;

  always #(CLK_P/2) clk = ~clk;

  nel_screen #(.NSLOT(NSLOT), .AW(AW), .IMM_W(IMM_W), .NREG(NREG)) i_nel_screen (.*);

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [STW-1:0] mk(logic fr, logic [5:0] d, logic [2:0] s,
                                          logic [SIW-1:0] ix, logic e, logic r);
    return {r, e, ix, s, d, fr, 1'b1, 1'b1};
  endfunction

  task automatic do_reset();
    rst_n = 0; req = 0;
    log_valid = 0; log_en = 0; log_nen = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic ld(logic [5:0] b, logic [AW-1:0] bv, logic du, logic [5:0] d,
                    logic [AW-1:0] dv, logic [IMM_W-1:0] im, logic [5:0] t,
                    logic [2:0] sz, logic fp);
    base_idx = b; base_val = bv; disp_use = du; disp_idx = d; disp_val = dv;
    imm = im; dst_idx = t; size = sz; is_fp = fp; req = 1;
    @(negedge clk);
    req = 0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R11 gne", gne, 0);
    check("R11 fne", fne, 0);
    check("R11 slots", slot_stat, 0);
    check("R11 outs", {done, do_load, alloc_err}, 0);
  endtask

  task automatic t_small_sizes();
    do_reset();
    ld(0, 32'h3, 0, 0, 0, 0, 1, 3'd0, 0);
    check("R2 byte odd ok", {do_load, gne[1]}, 2'b10);
    ld(0, 32'h1, 0, 0, 0, 0, 2, 3'd1, 0);
    check("R2 half odd", gne[2], 1);
    ld(0, 32'h2, 0, 0, 0, 0, 3, 3'd1, 0);
    check("R2 half even", gne[3], 0);
    ld(0, 32'h2, 0, 0, 0, 0, 4, 3'd2, 0);
    check("R2 word bit1", gne[4], 1);
    ld(0, 32'h4, 0, 0, 0, 0, 5, 3'd2, 0);
    check("R2 word aligned", gne[5], 0);
  endtask

  task automatic t_big_sizes();
    do_reset();
    ld(0, 32'h8, 0, 0, 0, 0, 3, 3'd3, 0);
    check("R3 dbl odd dst", gne[3], 1);
    ld(0, 32'h8, 0, 0, 0, 0, 4, 3'd3, 0);
    check("R3 dbl ok", gne[4], 0);
    ld(0, 32'h4, 0, 0, 0, 0, 10, 3'd3, 0);
    check("R3 dbl addr", gne[10], 1);
    ld(0, 32'h18, 0, 0, 0, 0, 8, 3'd4, 0);
    check("R3 quad addr", gne[8], 1);
    ld(0, 32'h20, 0, 0, 0, 0, 6, 3'd4, 0);
    check("R3 quad dst", gne[6], 1);
    ld(0, 32'h20, 0, 0, 0, 0, 12, 3'd4, 0);
    check("R3 quad ok", gne[12], 0);
  endtask

  task automatic t_propagate();
    do_reset();
    ld(0, 32'h1, 0, 0, 0, 0, 10, 3'd1, 0);
    check("R4 fault loads", {do_load, gne[10]}, 2'b11);
    ld(10, 32'h0, 0, 0, 0, 0, 12, 3'd2, 0);
    check("R5 base flag", {do_load, gne[12]}, 2'b01);
    ld(1, 32'h0, 1, 10, 32'h4, 0, 13, 3'd2, 0);
    check("R5 disp flag", {do_load, gne[13]}, 2'b01);
    ld(1, 32'h0, 0, 10, 0, 12'h4, 13, 3'd2, 0);
    check("R5 disp unused", {do_load, gne[13]}, 2'b10);
    ld(12, 32'h2, 0, 0, 0, 0, 14, 3'd2, 0);
    check("R4 fault over src", {do_load, gne[14]}, 2'b11);
  endtask

  task automatic t_vectors();
    do_reset();
    ld(0, 32'h1, 0, 0, 0, 0, 2, 3'd1, 1);
    check("R6 fp set", fne[2], 1);
    check("R6 int untouched", gne, 0);
    ld(2, 32'h0, 0, 0, 0, 0, 7, 3'd0, 0);
    check("R6 int ignores fp src", {do_load, gne[7]}, 2'b10);
    ld(2, 32'h0, 0, 0, 0, 0, 7, 3'd0, 1);
    check("R6 fp src", {do_load, fne[7]}, 2'b01);
  endtask

  task automatic t_log();
    logic [NSLOT*STW-1:0] snap;
    do_reset();
    log_nen = 2;
    log_valid = 1; log_en = 0;
    ld(0, 32'h100, 0, 0, 0, 12'hFFC, 7, 3'd2, 0);
    check("R7 en off", slot_stat, 0);
    log_valid = 0; log_en = 1;
    ld(0, 32'h100, 0, 0, 0, 12'hFFC, 7, 3'd2, 0);
    check("R7 valid off", slot_stat, 0);
    log_valid = 1;
    ld(0, 32'h100, 0, 0, 0, 12'hFFC, 7, 3'd2, 0);
    check("R9 slot0", slot_stat[0 +: STW], mk(0, 7, 2, 0, 0, 0));
    check("R1 imm addr", slot_addr[0 +: AW], 32'hFC);
    check("R8 err low", alloc_err, 0);
    ld(0, 32'h200, 1, 0, 32'h13, 0, 5, 3'd3, 1);
    check("R8 slot1", slot_stat[STW +: STW], mk(1, 5, 3, 1, 1, 1));
    check("R1 disp addr", slot_addr[AW +: AW], 32'h213);
    snap = slot_stat;
    ld(0, 32'h300, 0, 0, 0, 0, 9, 3'd0, 0);
    check("R8 full err", {done, alloc_err}, 2'b11);
    check("R8 full no write", slot_stat, snap);
    log_nen = 3;
    ld(0, 32'h300, 0, 0, 0, 0, 9, 3'd0, 0);
    check("R8 slot2", slot_stat[2*STW +: STW], mk(0, 9, 0, 2, 0, 0));
    check("R8 err clear", alloc_err, 0);
  endtask

  task automatic t_timing();
    logic [NREG-1:0] g;
    do_reset();
    check("R10 idle done", done, 0);
    ld(0, 32'h1, 0, 0, 0, 0, 20, 3'd1, 0);
    check("R10 done pulse", {done, gne[20]}, 2'b11);
    g = gne;
    @(negedge clk);
    check("R10 done drops", done, 0);
    check("R10 hold", gne, g);
  endtask

  initial begin
    t_reset();
    t_small_sizes();
    t_big_sizes();
    t_propagate();
    t_vectors();
    t_log();
    t_timing();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      nchk++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end
endmodule